// File: doc/BRIEF.md
# NAND Flash Host Interface

This block is the register-mapped front end that lets a processor drive an 8-bit NAND flash device. Software writes command, address and data bytes into three write-only ports. Each byte joins one shared first-in first-out queue with a tag that records its kind. A sequencer empties the queue onto the flash pins. A command byte drives a cycle with the command latch raised, an address byte drives a cycle with the address latch raised, and a data byte drives a plain write cycle. The width of the write strobe comes from a delay field in the control register.

A read takes two steps. Software first writes any value to the read-request port. Once the queue has drained, the sequencer runs one read-strobe cycle and captures the flash data bus into a read-data register. It then raises a ready flag, which software clears by writing a one to it. A status register reports the queue state, pending work and a synchronised copy of the flash ready line. An interrupt-flag register collects events that are cleared by writing ones. A mask register chooses which flags drive the interrupt pin.

Top module: `nand_host_if`

## Requirements
- R1: After reset the flash pins are idle (both strobes high, both latches low, data bus not driven). The status register reads 0x11 while the ready line is high. The interrupt-flag register reads 0 and the interrupt pin is low.
- R2: The register offsets are: 0 control, 1 status, 2 interrupt flags, 3 interrupt mask, 4 command, 5 address, 6 write data, 7 read request, 8 read data. Control keeps bits 9:0 and reads back zero above them. Bits 3:0 hold the write delay, bits 7:4 the read delay, bit 8 the width select and bit 9 the page-size select.
- R3: A command byte produces a write cycle with the command latch high and the byte on the flash data bus. The write strobe stays low for exactly write delay + 1 clocks.
- R4: An address byte produces a write cycle with the address latch high. A write-data byte produces a write cycle with both latches low.
- R5: Queued bytes leave in the order they were written. An idle sequencer takes the head entry in the clock after it enters the queue. Each write cycle is followed by one clock with the strobe high and one idle clock.
- R6: The queue holds 4 entries, and status bit 1 shows when it is full. A byte written while the queue is full is dropped and sets interrupt flag bit 1 (overflow).
- R7: A write to the read-request port starts one read cycle, whatever value it carries. The cycle waits until the queue is empty. The read strobe stays low for read delay + 1 clocks. The flash data bus is captured on the last low clock into the read-data register, and interrupt flag bit 3 (data ready) is set.
- R8: Writing a one to an interrupt-flag bit clears it. Writing a zero to a bit leaves it unchanged.
- R9: Status bit 0 follows the flash ready line through a two-stage synchroniser. A rising edge of the ready line sets interrupt flag bit 0.
- R10: The interrupt pin is the registered OR of the flags that are enabled in the 5-bit mask. A mask of 0 holds the pin low.
- R11: Status bit 4 shows an empty queue. Status bit 2 shows queued or active write work, and status bit 3 shows a pending or active read. Interrupt flag bit 2 is set when the queue becomes empty. Interrupt flag bit 4 is set when a write cycle ends with the queue empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Registered read data for the offset on bus_addr |
| irq | output | 1 | Interrupt request |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_dq_out | output | 8 | Flash data bus, driven value |
| fl_dq_oe | output | 1 | Flash data bus output enable |
| fl_dq_in | input | 8 | Flash data bus, sampled value |
| fl_rdy | input | 1 | Flash ready/busy line (high = ready) |

## Verification
Register read data is due one clock after the offset is presented. An interrupt flag is due one clock after its event, and the interrupt pin follows one clock after that. The ready line reaches status two clocks after it changes. A queued byte's strobe falls one clock after the push when the sequencer is idle, and each entry then takes write delay + 3 clocks. Inputs change and outputs are sampled on falling edges. A scoreboard monitor measures every strobe's low time against the programmed delay as the pins change, so the bench never depends on a fixed start cycle. Read completion is detected by polling the ready flag, and the overflow case writes bytes back to back so that the sixth one is the one dropped.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [1:0] {TAG_CMD = 2'd0, TAG_ADDR = 2'd1, TAG_DATA = 2'd2} wtag_e;

  typedef struct packed {
    wtag_e      tag;
    logic [7:0] byte_v;
  } wentry_t;

  localparam logic [3:0] OFS_CTRL  = 4'd0;
  localparam logic [3:0] OFS_STAT  = 4'd1;
  localparam logic [3:0] OFS_IFLAG = 4'd2;
  localparam logic [3:0] OFS_IMASK = 4'd3;
  localparam logic [3:0] OFS_CMD   = 4'd4;
  localparam logic [3:0] OFS_ADDR  = 4'd5;
  localparam logic [3:0] OFS_WDATA = 4'd6;
  localparam logic [3:0] OFS_RDREQ = 4'd7;
  localparam logic [3:0] OFS_RDATA = 4'd8;

  localparam int NFLAGS = 5;
endpackage

// File: rtl/nfc_wbuf.sv
module nfc_wbuf
  import nfc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    push,
  input  wentry_t push_entry,
  input  logic    pop,
  output wentry_t head,
  output logic    full,
  output logic    empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  wentry_t           mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  a_r6_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
    full |-> !push);
endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
  import nfc_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DLY_W-1:0] wr_dly,
  input  logic [DLY_W-1:0] rd_dly,
  input  logic             have_entry,
  input  wentry_t          head,
  output logic             pop,
  input  logic             rd_start,
  output logic             rd_pending,
  output logic             wr_active,
  output logic             wr_done,
  output logic             rd_done,
  output logic [7:0]       rd_byte,
  output logic             fl_cle,
  output logic             fl_ale,
  output logic             fl_we_n,
  output logic             fl_re_n,
  output logic [7:0]       fl_dq_out,
  output logic             fl_dq_oe,
  input  logic [7:0]       fl_dq_in
);
  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_GAP} st_e;
  st_e              st;
  logic [DLY_W-1:0] cnt;
  logic             rd_pend;

  assign pop        = (st == S_IDLE) && have_entry;
  assign rd_pending = rd_pend || (st == S_RD);
  assign wr_active  = (st == S_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cnt <= '0; rd_pend <= 1'b0;
      fl_cle <= 1'b0; fl_ale <= 1'b0; fl_we_n <= 1'b1; fl_re_n <= 1'b1;
      fl_dq_out <= '0; fl_dq_oe <= 1'b0; rd_byte <= '0;
      wr_done <= 1'b0; rd_done <= 1'b0;
    end else begin
      wr_done <= 1'b0;
      rd_done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (have_entry) begin
            st        <= S_WR;
            cnt       <= wr_dly;
            fl_we_n   <= 1'b0;
            fl_cle    <= (head.tag == TAG_CMD);
            fl_ale    <= (head.tag == TAG_ADDR);
            fl_dq_out <= head.byte_v;
            fl_dq_oe  <= 1'b1;
          end else if (rd_pend) begin
            st      <= S_RD;
            cnt     <= rd_dly;
            fl_re_n <= 1'b0;
            rd_pend <= 1'b0;
          end
        end
        S_WR: begin
          if (cnt == '0) begin
            st      <= S_GAP;
            fl_we_n <= 1'b1;
            wr_done <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        S_RD: begin
          if (cnt == '0) begin
            st      <= S_GAP;
            fl_re_n <= 1'b1;
            rd_byte <= fl_dq_in;
            rd_done <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        default: begin
          st       <= S_IDLE;
          fl_cle   <= 1'b0;
          fl_ale   <= 1'b0;
          fl_dq_oe <= 1'b0;
        end
      endcase
      if (rd_start) rd_pend <= 1'b1;
    end
  end

  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_re_n));
  a_r4_latches_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(fl_cle && fl_ale));
endmodule

// File: rtl/nfc_irq.sv
module nfc_irq
  import nfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NFLAGS-1:0] events,
  input  logic              clr_we,
  input  logic [NFLAGS-1:0] clr_bits,
  input  logic [NFLAGS-1:0] mask,
  output logic [NFLAGS-1:0] flags,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~(clr_we ? clr_bits : '0)) | events;
      irq   <= |(flags & mask);
    end
  end

  a_r10_mask_zero_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq);
endmodule

// File: rtl/nand_host_if.sv
module nand_host_if
  import nfc_pkg::*;
#(
  parameter int BUS_W    = 16,
  parameter int WB_DEPTH = 4,
  parameter int DLY_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq,
  output logic             fl_cle,
  output logic             fl_ale,
  output logic             fl_we_n,
  output logic             fl_re_n,
  output logic [7:0]       fl_dq_out,
  output logic             fl_dq_oe,
  input  logic [7:0]       fl_dq_in,
  input  logic             fl_rdy
);
  localparam int CTRL_W = 2 * DLY_W + 2;

  logic [CTRL_W-1:0] ctrl;
  logic [NFLAGS-1:0] imask, iflags, events;
  logic              rdy_s1, rdy_s2, empty_prev;
  logic              wb_full, wb_empty, wb_pop, wb_push, queue_wr;
  wentry_t           wb_head, push_entry;
  logic              rd_start, rd_pending, wr_active, wr_done, rd_done;
  logic [7:0]        rd_byte;
  logic [NFLAGS-1:0] status;

  always_comb begin
    queue_wr = 1'b0;
    push_entry.tag = TAG_DATA;
    push_entry.byte_v = bus_wdata[7:0];
    if (bus_wr) begin
      case (bus_addr)
        OFS_CMD:   begin queue_wr = 1'b1; push_entry.tag = TAG_CMD;  end
        OFS_ADDR:  begin queue_wr = 1'b1; push_entry.tag = TAG_ADDR; end
        OFS_WDATA: begin queue_wr = 1'b1; push_entry.tag = TAG_DATA; end
        default:   queue_wr = 1'b0;
      endcase
    end
  end

  assign wb_push  = queue_wr && !wb_full;
  assign rd_start = bus_wr && (bus_addr == OFS_RDREQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0; imask <= '0;
      rdy_s1 <= 1'b1; rdy_s2 <= 1'b1; empty_prev <= 1'b1;
    end else begin
      if (bus_wr && bus_addr == OFS_CTRL)  ctrl  <= bus_wdata[CTRL_W-1:0];
      if (bus_wr && bus_addr == OFS_IMASK) imask <= bus_wdata[NFLAGS-1:0];
      rdy_s1     <= fl_rdy;
      rdy_s2     <= rdy_s1;
      empty_prev <= wb_empty;
    end
  end

  assign events = {wr_done && wb_empty,
                   rd_done,
                   wb_empty && !empty_prev,
                   queue_wr && wb_full,
                   rdy_s1 && !rdy_s2};

  assign status = {wb_empty, rd_pending, (!wb_empty || wr_active), wb_full, rdy_s2};

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        OFS_CTRL:  bus_rdata <= BUS_W'(ctrl);
        OFS_STAT:  bus_rdata <= BUS_W'(status);
        OFS_IFLAG: bus_rdata <= BUS_W'(iflags);
        OFS_IMASK: bus_rdata <= BUS_W'(imask);
        OFS_RDATA: bus_rdata <= BUS_W'(rd_byte);
        default:   bus_rdata <= '0;
      endcase
    end
  end

  nfc_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
    .clk(clk), .rst(rst), .push(wb_push), .push_entry(push_entry),
    .pop(wb_pop), .head(wb_head), .full(wb_full), .empty(wb_empty)
  );

  nfc_seq #(.DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst(rst),
    .wr_dly(ctrl[DLY_W-1:0]), .rd_dly(ctrl[2*DLY_W-1:DLY_W]),
    .have_entry(!wb_empty), .head(wb_head), .pop(wb_pop),
    .rd_start(rd_start), .rd_pending(rd_pending), .wr_active(wr_active),
    .wr_done(wr_done), .rd_done(rd_done), .rd_byte(rd_byte),
    .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
  );

  nfc_irq u_irq (
    .clk(clk), .rst(rst), .events(events),
    .clr_we(bus_wr && bus_addr == OFS_IFLAG), .clr_bits(bus_wdata[NFLAGS-1:0]),
    .mask(imask), .flags(iflags), .irq(irq)
  );

  a_r7_read_after_drain: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_re_n) |-> $past(wb_empty));
  a_r6_overflow_needs_full: assert property (@(posedge clk) disable iff (rst)
    $rose(iflags[1]) |-> $past(wb_full));
endmodule

// File: tb/nand_host_if_test.sv
module nand_host_if_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe;
  logic [7:0]  fl_dq_out;
  logic [7:0]  fl_dq_in = 8'h00;
  logic        fl_rdy = 1'b1;

  always #10 clk = ~clk;

  nand_host_if uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_rdy(fl_rdy)
  );

  typedef struct {
    bit [1:0] tag;
    bit [7:0] b;
    int       len;
  } wexp_t;

  wexp_t exp_q[$];
  int    n_chk = 0, n_fail = 0;
  int    exp_rlen = 1, n_reads = 0;
  bit    done = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic queue_byte(input logic [3:0] port, input bit [7:0] b, input int len);
    wexp_t e;
    e.tag = (port == 4'd4) ? 2'd0 : (port == 4'd5) ? 2'd1 : 2'd2;
    e.b = b; e.len = len;
    exp_q.push_back(e);
    wr(port, {8'h00, b});
  endtask

  // Scoreboard monitor: measures each strobe pulse and compares with expectations
  initial begin
    int    wlow = 0, rlow = 0;
    bit    c_cle = 0, c_ale = 0;
    bit [7:0] c_dq = '0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (!fl_we_n) begin
          wlow++; c_cle = fl_cle; c_ale = fl_ale; c_dq = fl_dq_out;
        end else if (wlow > 0) begin
          if (exp_q.size() == 0) check(0, "R5 unexpected write cycle", c_dq, 0);
          else begin
            wexp_t e;
            e = exp_q.pop_front();
            check(c_dq == e.b, "R5 byte order", c_dq, e.b);
            check(wlow == e.len, "R3 write strobe width", wlow, e.len);
            check({c_ale, c_cle} == ((e.tag == 2'd0) ? 2'b01 : (e.tag == 2'd1) ? 2'b10 : 2'b00),
                  "R4 latch kind", {c_ale, c_cle}, e.tag);
          end
          wlow = 0;
        end
        if (!fl_re_n) begin
          if (rlow == 0) check(exp_q.size() == 0, "R7 read waits for drain", exp_q.size(), 0);
          rlow++;
        end else if (rlow > 0) begin
          n_reads++;
          check(rlow == exp_rlen, "R7 read strobe width", rlow, exp_rlen);
          rlow = 0;
        end
      end
    end
  end

  task automatic wait_ready_flag();
    logic [15:0] v;
    for (int i = 0; i < 60; i++) begin
      rd(4'd2, v);
      if (v[3]) break;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(fl_we_n && fl_re_n && !fl_cle && !fl_ale && !fl_dq_oe, "R1 idle pins",
          {fl_we_n, fl_re_n, fl_cle, fl_ale, fl_dq_oe}, 5'b11000);
    rd(4'd1, v); check(v == 16'h0011, "R1 status", v, 16'h0011);
    rd(4'd2, v); check(v == 16'h0000, "R1 flags", v, 0);
    check(irq == 1'b0, "R1 irq low", irq, 0);

    // R2 control register
    wr(4'd0, 16'hFF32);
    rd(4'd0, v); check(v == 16'h0332, "R2 control readback", v, 16'h0332);
    wr(4'd0, 16'h0032);

    // R3 R4 R5 command, address, data sequence with write delay 2
    queue_byte(4'd4, 8'h70, 3);
    queue_byte(4'd5, 8'h12, 3);
    queue_byte(4'd6, 8'hA5, 3);
    queue_byte(4'd6, 8'h5A, 3);
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R5 all bytes drained", exp_q.size(), 0);
    rd(4'd1, v); check(v == 16'h0011, "R11 status after drain", v, 16'h0011);
    rd(4'd2, v); check(v == 16'h0014, "R11 drain and done flags", v, 16'h0014);
    check(irq == 1'b0, "R10 mask zero keeps irq low", irq, 0);

    // R8 write-one-to-clear
    wr(4'd2, 16'h0004);
    rd(4'd2, v); check(v == 16'h0010, "R8 partial clear", v, 16'h0010);
    wr(4'd2, 16'h001F);
    rd(4'd2, v); check(v == 16'h0000, "R8 full clear", v, 0);

    // R7 reads, value written to the request port ignored
    exp_rlen = 4;
    fl_dq_in = 8'hC3;
    wr(4'd7, 16'hBEEF);
    wait_ready_flag();
    rd(4'd8, v); check(v == 16'h00C3, "R7 read data", v, 16'h00C3);
    wr(4'd2, 16'h0008);
    fl_dq_in = 8'h3C;
    queue_byte(4'd4, 8'h00, 3);
    wr(4'd7, 16'h0000);
    rd(4'd1, v); check(v[3] == 1'b1, "R11 read pending", v[3], 1);
    wait_ready_flag();
    rd(4'd8, v); check(v == 16'h003C, "R7 read after queued command", v, 16'h003C);
    check(n_reads == 2, "R7 one cycle per request", n_reads, 2);

    // R10 masked interrupt
    wr(4'd3, 16'h0008);
    repeat (2) @(negedge clk);
    check(irq == 1'b1, "R10 enabled flag raises irq", irq, 1);
    wr(4'd2, 16'h001F);
    repeat (2) @(negedge clk);
    check(irq == 1'b0, "R10 irq drops after clear", irq, 0);
    wr(4'd3, 16'h0000);

    // R9 ready line mirror and rising-edge flag
    fl_rdy = 1'b0;
    repeat (4) @(negedge clk);
    rd(4'd1, v); check(v[0] == 1'b0, "R9 busy mirrored", v[0], 0);
    rd(4'd2, v); check(v[0] == 1'b0, "R9 no flag on falling edge", v[0], 0);
    fl_rdy = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'd1, v); check(v[0] == 1'b1, "R9 ready mirrored", v[0], 1);
    rd(4'd2, v); check(v[0] == 1'b1, "R9 ready edge flag", v[0], 1);
    wr(4'd2, 16'h001F);

    // R6 overflow: write delay 15, six back-to-back data writes, sixth dropped
    wr(4'd0, 16'h003F);
    for (int i = 0; i < 5; i++) begin
      wexp_t e;
      e.tag = 2'd2; e.b = 8'h80 + 8'(i); e.len = 16;
      exp_q.push_back(e);
    end
    for (int i = 0; i < 6; i++) wr(4'd6, 16'h0080 + 16'(i));
    rd(4'd1, v); check(v == 16'h0007, "R6 full status", v, 16'h0007);
    rd(4'd2, v); check(v[1] == 1'b1, "R6 overflow flag", v[1], 1);
    repeat (150) @(negedge clk);
    check(exp_q.size() == 0, "R6 five bytes sent", exp_q.size(), 0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule